// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block collects interrupt requests from peripherals into one pending register and drives a single level-sensitive interrupt line upstream. Peripherals set and clear request bits through two bitvector inputs. An enable mask that software can program decides which pending bits may raise the line. The line is high whenever at least one pending bit is also enabled. It is recomputed on every edge that changes the pending register or the mask.

Software reaches the block through a byte-wide register port with a combinational read path. The primary mask is written as a byte of mask bits, where a 1 disables a source. It is held internally as the complement, which is the enable set, and it reads back as written. Software can read the pending register as a byte or as a wide word. It can retire one request by writing that request's bit index. A secondary controller exists only as stub registers: a plain mask byte and a status that always reads zero.

Top module: `irq_aggregator`

## Requirements
- R1: A write to address 0 stores the complement of `wdata` as the enable mask. A byte read of address 0 returns the complement of the enable mask, which is the byte last written.
- R2: `irq_o` is high exactly when the bitwise AND of the pending register and the enable mask is nonzero. It changes on the same clock edge as the state it depends on.
- R3: A mask write updates `irq_o` at that edge. The line rises when enabled requests appear and falls when none remain.
- R4: A write to address 2 clears the pending bit whose index is `wdata[3:0]`. Bits 7:4 of the written byte are ignored. `irq_o` falls at that edge if no enabled request remains.
- R5: `set_i` ORs its bits into the pending register and `clr_i` clears its bits from it, both on the next edge.
- R6: A byte read (`rd_wide`=0) of address 1 returns the pending register in `rdata[7:0]`. A wide read (`rd_wide`=1) of address 1 returns the pending register zero-extended to the full width of `rdata`. A wide read of any other address returns zero. Byte reads always return zero in `rdata` above bit 7.
- R7: A write to address 3 stores `wdata` unchanged, and a byte read of address 3 returns it. Address 4 always reads zero. Writes to addresses 4 and 5 change neither the pending register nor the enable mask.
- R8: After reset the pending register is zero, the enable mask is zero (address 0 reads 0xFF), the secondary mask is zero and `irq_o` is low.
- R9: An acknowledge write whose index `wdata[3:0]` is 8 or more leaves the pending register unchanged.
- R10: When `set_i` and either `clr_i` or an acknowledge target the same bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_wide | input | 1 | Selects a wide read instead of a byte read |
| addr | input | 3 | Register address (0 pmask, 1 status, 2 ack, 3 smask, 4 sstatus, 5 sack) |
| wdata | input | 8 | Write data |
| rdata | output | 64 | Combinational read data |
| set_i | input | 8 | Request bits to set |
| clr_i | input | 8 | Request bits to clear |
| irq_o | output | 1 | Level interrupt line upstream |

## Verification
The assertions assume that `wr_en` and `addr` are known in every cycle after reset, and that `set_i` and `clr_i` are bitvectors that may carry any pattern, including overlaps with each other and with an acknowledge. The stimulus drives every input away from the clock edge and holds it steady for a whole cycle. It uses only addresses 0 to 5 for writes. It sweeps all mask bytes and all pending patterns against a spread of masks, and it exercises the overlap cases on purpose, so the properties are checked inside the input space they assume.

// File: rtl/irq_aggregator_pkg.sv
package irq_aggregator_pkg;

    localparam int BYTE_W  = 8;
    localparam int ACK_IDX = 4;

    typedef enum logic [2:0] {
        SEL_PMASK = 3'd0,
        SEL_PSTAT = 3'd1,
        SEL_PACK  = 3'd2,
        SEL_SMASK = 3'd3,
        SEL_SSTAT = 3'd4,
        SEL_SACK  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        reg_sel_e          sel;
        logic [BYTE_W-1:0] data;
    } bus_wr_t;

    function automatic logic is_write(bus_wr_t w, reg_sel_e s);
        return w.valid && (w.sel == s);
    endfunction

endpackage

// File: rtl/irqagg_mask_bank.sv
module irqagg_mask_bank
    import irq_aggregator_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_wr_t       wr_i,
    output logic [DW-1:0] en_q_o,
    output logic [DW-1:0] en_d_o,
    output logic [DW-1:0] sec_q_o
);
    logic [DW-1:0] en_q, en_d, sec_q, sec_d;

    always_comb begin
        en_d  = en_q;
        sec_d = sec_q;
        if (is_write(wr_i, SEL_PMASK)) en_d  = ~wr_i.data[DW-1:0];
        if (is_write(wr_i, SEL_SMASK)) sec_d = wr_i.data[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sec_q <= '0;
        end else begin
            en_q  <= en_d;
            sec_q <= sec_d;
        end
    end

    assign en_q_o  = en_q;
    assign en_d_o  = en_d;
    assign sec_q_o = sec_q;

    AST_MASK_INVERT: assert property (@(posedge clk) disable iff (rst)
        (wr_i.valid && wr_i.sel == SEL_PMASK) |=> (en_q == ~$past(wr_i.data[DW-1:0]))); // R1

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(wr_i.valid && wr_i.sel == SEL_PMASK)) |=> $stable(en_q)); // R7
endmodule

// File: rtl/irqagg_pending.sv
module irqagg_pending
    import irq_aggregator_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    set_i,
    input  logic [NSRC-1:0]    clr_i,
    input  logic               ack_v_i,
    input  logic [ACK_IDX-1:0] ack_idx_i,
    output logic [NSRC-1:0]    pend_q_o,
    output logic [NSRC-1:0]    pend_d_o
);
    logic [NSRC-1:0] pend_q, pend_d, ack_vec;

    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        assign ack_vec[g] = ack_v_i && (ack_idx_i == ACK_IDX'(g));
        assign pend_d[g]  = set_i[g] | (pend_q[g] & ~clr_i[g] & ~ack_vec[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pend_q_o = pend_q;
    assign pend_d_o = pend_d;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R10

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0)); // R5

    AST_ACK_RANGE: assert property (@(posedge clk) disable iff (rst)
        (ack_v_i && int'(ack_idx_i) >= NSRC && set_i == '0 && clr_i == '0) |=> $stable(pend_q)); // R9
endmodule

// File: rtl/irqagg_read_mux.sv
module irqagg_read_mux
    import irq_aggregator_pkg::*;
#(
    parameter int DW  = 8,
    parameter int RDW = 64
) (
    input  reg_sel_e       sel_i,
    input  logic           wide_i,
    input  logic [DW-1:0]  en_i,
    input  logic [DW-1:0]  pend_i,
    input  logic [DW-1:0]  sec_i,
    output logic [RDW-1:0] rdata_o
);
    logic [DW-1:0] byte_val;

    always_comb begin
        unique case (sel_i)
            SEL_PMASK: byte_val = ~en_i;
            SEL_PSTAT: byte_val = pend_i;
            SEL_SMASK: byte_val = sec_i;
            default:   byte_val = '0;
        endcase
    end

    always_comb begin
        rdata_o = '0;
        if (wide_i) begin
            if (sel_i == SEL_PSTAT) rdata_o[DW-1:0] = pend_i;
        end else begin
            rdata_o[DW-1:0] = byte_val;
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_aggregator_pkg::*;
#(
    parameter int DW  = 8,
    parameter int RDW = 64,
    parameter int AW  = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic           rd_wide,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [RDW-1:0] rdata,
    input  logic [DW-1:0]  set_i,
    input  logic [DW-1:0]  clr_i,
    output logic           irq_o
);
    localparam int NSRC = DW;

    bus_wr_t         wr;
    reg_sel_e        sel;
    logic [DW-1:0]   en_q, en_d, sec_q, pend_q, pend_d;
    logic            irq_q;

    assign sel      = reg_sel_e'(addr[2:0]);
    assign wr.valid = wr_en;
    assign wr.sel   = sel;
    assign wr.data  = BYTE_W'(wdata);

    irqagg_mask_bank #(.DW(DW)) u_mask (
        .clk(clk), .rst(rst), .wr_i(wr),
        .en_q_o(en_q), .en_d_o(en_d), .sec_q_o(sec_q)
    );

    irqagg_pending #(.NSRC(NSRC)) u_pend (
        .clk(clk), .rst(rst), .set_i(set_i), .clr_i(clr_i),
        .ack_v_i(is_write(wr, SEL_PACK)), .ack_idx_i(wdata[ACK_IDX-1:0]),
        .pend_q_o(pend_q), .pend_d_o(pend_d)
    );

    irqagg_read_mux #(.DW(DW), .RDW(RDW)) u_rd (
        .sel_i(sel), .wide_i(rd_wide), .en_i(en_q), .pend_i(pend_q),
        .sec_i(sec_q), .rdata_o(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(pend_d & en_d);
    end

    assign irq_o = irq_q;

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_o == (|(pend_q & en_q))); // R2

    AST_MASK_RAISE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_PMASK && (|(pend_q & ~wdata)) && set_i == '0 && clr_i == '0) |=> irq_o); // R3

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_PACK && int'(wdata[ACK_IDX-1:0]) < NSRC && set_i == '0 && clr_i == '0)
        |=> !pend_q[$past(wdata[2:0])]); // R4
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst, wr_en, rd_wide, irq_o;
    logic [2:0]  addr;
    logic [7:0]  wdata, set_i, clr_i;
    logic [63:0] rdata;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_wide(rd_wide), .addr(addr),
        .wdata(wdata), .rdata(rdata), .set_i(set_i), .clr_i(clr_i), .irq_o(irq_o)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1; addr = a; wdata = d; tick(); wr_en = 0;
    endtask

    task automatic rd(logic [2:0] a, logic w, output logic [63:0] v);
        addr = a; rd_wide = w; #1; v = rdata; rd_wide = 0;
    endtask

    task automatic load_pend(logic [7:0] p);
        clr_i = 8'hFF; tick(); clr_i = 0;
        set_i = p; tick(); set_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [7:0] exp_p;
        rst = 1; wr_en = 0; rd_wide = 0; addr = 0; wdata = 0; set_i = 0; clr_i = 0;
        tick(); tick(); rst = 0;

        // R8 reset state
        rd(3'd0, 0, v); chk("R8 mask", v, 64'hFF);
        rd(3'd1, 0, v); chk("R8 pend", v, 64'h0);
        rd(3'd3, 0, v); chk("R8 smask", v, 64'h0);
        chk("R8 irq", 64'(irq_o), 64'h0);

        // R1 every mask byte reads back as written
        for (int m = 0; m < 256; m++) begin
            wr(3'd0, 8'(m));
            rd(3'd0, 0, v); chk("R1 readback", v, 64'(m));
        end

        // R2 R5 R6 pending sweep against masks
        for (int k = 0; k < 16; k++) begin
            wr(3'd0, 8'(k * 17));
            for (int p = 0; p < 256; p++) begin
                load_pend(8'(p));
                rd(3'd1, 0, v); chk("R5 pend byte", v, 64'(p));
                rd(3'd1, 1, v); chk("R6 pend wide", v, 64'(p));
                chk("R2 irq", 64'(irq_o), 64'(|(8'(p) & ~8'(k * 17))));
            end
        end
        rd(3'd0, 1, v); chk("R6 wide other", v, 64'h0);

        // R5 partial clear
        load_pend(8'hF0);
        clr_i = 8'h30; tick(); clr_i = 0;
        rd(3'd1, 0, v); chk("R5 clear", v, 64'hC0);

        // R3 mask write moves the line
        load_pend(8'h0F);
        wr(3'd0, 8'hFF); chk("R3 all masked", 64'(irq_o), 64'h0);
        wr(3'd0, 8'hF0); chk("R3 rise", 64'(irq_o), 64'h1);
        wr(3'd0, 8'h0F); chk("R3 fall", 64'(irq_o), 64'h0);

        // R4 acknowledge by index
        wr(3'd0, 8'h00);
        load_pend(8'hFF);
        exp_p = 8'hFF;
        for (int i = 0; i < 8; i++) begin
            wr(3'd2, 8'(i) | 8'hA0);
            exp_p[i] = 1'b0;
            rd(3'd1, 0, v); chk("R4 ack", v, 64'(exp_p));
            chk("R4 irq", 64'(irq_o), 64'(exp_p != 0));
        end

        // R9 out-of-range indices
        load_pend(8'hFF);
        for (int i = 8; i < 16; i++) begin
            wr(3'd2, 8'(i));
            rd(3'd1, 0, v); chk("R9 no effect", v, 64'hFF);
        end

        // R10 set beats clear and ack
        load_pend(8'h00);
        set_i = 8'h01; clr_i = 8'h01; tick(); set_i = 0; clr_i = 0;
        rd(3'd1, 0, v); chk("R10 set vs clr", v, 64'h01);
        set_i = 8'h04; wr(3'd2, 8'h02); set_i = 0;
        rd(3'd1, 0, v); chk("R10 set vs ack", v, 64'h05);

        // R7 secondary stubs
        wr(3'd0, 8'h3C);
        load_pend(8'h81);
        wr(3'd3, 8'h5A);
        rd(3'd3, 0, v); chk("R7 smask", v, 64'h5A);
        rd(3'd4, 0, v); chk("R7 sstat", v, 64'h0);
        rd(3'd4, 1, v); chk("R7 sstat wide", v, 64'h0);
        wr(3'd5, 8'h00); wr(3'd5, 8'h07); wr(3'd4, 8'hFF);
        rd(3'd1, 0, v); chk("R7 sack pend", v, 64'h81);
        rd(3'd0, 0, v); chk("R7 sack mask", v, 64'h3C);
        chk("R7 irq", 64'(irq_o), 64'h1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule